// File: doc/BRIEF.md
# DRAM Refresh Timing Controller

This block keeps an asynchronous DRAM array refreshed and shares the array's strobes with a host access sequencer. A free-running interval counter marks one refresh as owed every period. Owed refreshes are slotted into the gaps between host accesses, so the host is never locked out for long. The block drives the active-low row strobe, the active-low column strobe and a multiplexed row-address bus. All timing limits are parameters counted in clock cycles.

Three refresh styles are offered, chosen by a static mode input. In the row-strobe-only style the block drives a row number from its own counter. In the column-first style the column strobe falls ahead of the row strobe, so the DRAM uses its internal row counter and no address is driven. In the hidden style a refresh is chained directly onto a host access while the column strobe stays low. The host holds its request high for as long as it wants accesses. Each grant burst covers one access: the row address setup phase followed by the row strobe low phase.

The owed count saturates at a parameterised limit. When that limit is reached, the next cycle the block starts is a refresh, even if the host is asking for an access. After reset both strobes stay inactive for a power-up delay.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: While reset is asserted, and for PWRUP_CYC clocks after it is released, ras_n_o and cas_n_o are high and host_grant_o is low; addr_o reads 0 during reset.
- R2: Every interval with ras_n_o low, whether for a host access or for a refresh, lasts exactly T_RAS clocks.
- R3: Between two ras_n_o low intervals, ras_n_o stays high for at least T_RP clocks. A host request that arrives during a refresh is not granted before that precharge has elapsed.
- R4: A host access holds host_grant_o high for T_ASR clocks before ras_n_o falls and through the whole low interval. addr_o equals host_row_i for that span. cas_n_o falls T_RAH clocks after ras_n_o falls and stays low to the end of the low interval.
- R5: With mode_i = 0 (row-strobe-only), a refresh keeps cas_n_o high. addr_o carries the internal row number, stable for T_ASR clocks before ras_n_o falls and throughout the low interval.
- R6: The internal row number is 0 after reset. It advances by one after each completed mode-0 refresh and wraps from ROWS-1 to 0.
- R7: In mode 1 (column-first) and mode 3, and for any refresh in mode 2 that does not follow an access, cas_n_o falls exactly T_CSR clocks before ras_n_o. addr_o reads 0. cas_n_o returns high after T_CHR clocks of ras_n_o low.
- R8: In mode 2 (hidden), when a refresh is owed at the end of a host access, ras_n_o rises for exactly T_RP clocks while cas_n_o stays low. ras_n_o then falls for the refresh, and cas_n_o is released after T_CHR clocks of ras_n_o low.
- R9: One refresh becomes owed every PERIOD_CYC clocks after reset. Refreshes started never exceed the periods elapsed. With no host requests, every owed refresh runs within the same period.
- R10: When MAX_OWED refreshes are owed and the block is idle, the next cycle started is a refresh and not an access. Under a continuous host request, the periods elapsed minus the refreshes started never exceeds MAX_OWED+1.
- R11: host_grant_o is low throughout every refresh cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Refresh style: 0 row-strobe-only, 1 column-first, 2 hidden, 3 as 1; changed only while idle |
| host_req_i | input | 1 | Host asks for an access cycle (level) |
| host_row_i | input | ROW_W | Row address for the host access |
| host_grant_o | output | 1 | Host access in progress |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| addr_o | output | ROW_W | Multiplexed row address |

## Verification
The hardest case to reach is the forced-priority case. The owed count must sit at its limit while the host keeps asking, and in hidden mode a refresh must become owed exactly as an access ends. The bench holds the request high for hundreds of cycles in every mode, using a short refresh period and an owed limit of two, so that the limit is reached repeatedly. A pseudo-random request pattern then lands refreshes at many offsets against accesses. A strobe-level monitor rebuilds every cycle from the pins alone, classifies it, and measures each edge distance against the parameters.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;

  typedef enum logic [3:0] {
    S_PWRUP,
    S_IDLE,
    S_ACC_SETUP,
    S_ACC_RAS,
    S_ROR_SETUP,
    S_CBR_SETUP,
    S_HID_PRE,
    S_REF_RAS,
    S_PRE
  } seq_state_e;

  localparam logic [1:0] MODE_RAS_ONLY  = 2'd0;
  localparam logic [1:0] MODE_CAS_FIRST = 2'd1;
  localparam logic [1:0] MODE_HIDDEN    = 2'd2;

endpackage

// File: rtl/refresh_interval.sv
module refresh_interval #(
  parameter int PERIOD_CYC = 1560,
  parameter int MAX_OWED   = 4,
  localparam int PW = $clog2(PERIOD_CYC + 1),
  localparam int OW = $clog2(MAX_OWED + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take_i,
  output logic owed_any_o,
  output logic owed_full_o
);

  logic [PW-1:0] per_q, per_d;
  logic [OW-1:0] owed_q, owed_d;
  logic          tick;
  logic          owed_en;

  always_comb begin
    tick   = (per_q == '0);
    per_d  = tick ? PW'(PERIOD_CYC - 1) : per_q - 1'b1;
    owed_d = owed_q;
    owed_en = 1'b0;
    if (tick && !take_i && owed_q != OW'(MAX_OWED)) begin
      owed_d  = owed_q + 1'b1;
      owed_en = 1'b1;
    end else if (take_i && !tick && owed_q != '0) begin
      owed_d  = owed_q - 1'b1;
      owed_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q  <= PW'(PERIOD_CYC - 1);
      owed_q <= '0;
    end else begin
      per_q <= per_d;
      if (owed_en) owed_q <= owed_d;
    end
  end

  assign owed_any_o  = (owed_q != '0);
  assign owed_full_o = (owed_q == OW'(MAX_OWED));

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && !take_i && owed_q == OW'(MAX_OWED))); // R10

  AST_TAKE_ONLY_OWED: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |-> owed_q != '0); // R9

endmodule

// File: rtl/refresh_row_counter.sv
module refresh_row_counter #(
  parameter int ROWS = 256,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  output logic [ROW_W-1:0] row_o
);

  logic [ROW_W-1:0] row_q, row_d;

  always_comb begin
    row_d = (row_q == ROW_W'(ROWS - 1)) ? '0 : row_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) row_q <= '0;
    else if (adv_i) row_q <= row_d;
  end

  assign row_o = row_q;

  AST_ROW_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    row_q <= ROW_W'(ROWS - 1)); // R6

endmodule

// File: rtl/refresh_sequencer.sv
module refresh_sequencer
  import dram_refresh_pkg::*;
#(
  parameter int ROW_W     = 8,
  parameter int PWRUP_CYC = 20,
  parameter int T_RAS     = 8,
  parameter int T_RP      = 6,
  parameter int T_ASR     = 1,
  parameter int T_RAH     = 2,
  parameter int T_CSR     = 1,
  parameter int T_CHR     = 2,
  localparam int CNT_W = $clog2(PWRUP_CYC + T_RAS + T_RP + T_ASR + T_CSR + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic             host_req_i,
  input  logic [ROW_W-1:0] host_row_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic             owed_any_i,
  input  logic             owed_full_i,
  output logic             take_o,
  output logic             row_adv_o,
  output logic             host_grant_o,
  output logic             ras_n_o,
  output logic             cas_n_o,
  output logic [ROW_W-1:0] addr_o
);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             last;
  logic             is_ror;
  logic             is_hid;
  logic             cas_low;

  function automatic logic [CNT_W-1:0] ld(input int v);
    return CNT_W'(v - 1);
  endfunction

  assign is_ror = (mode_i == MODE_RAS_ONLY);
  assign is_hid = (mode_i == MODE_HIDDEN);
  assign last   = (cnt_q == '0);

  always_comb begin
    state_d   = state_q;
    cnt_d     = last ? cnt_q : cnt_q - 1'b1;
    take_o    = 1'b0;
    row_adv_o = 1'b0;
    unique case (state_q)
      S_PWRUP: if (last) state_d = S_IDLE;
      S_IDLE: begin
        if (owed_full_i || (!host_req_i && owed_any_i)) begin
          take_o = 1'b1;
          if (is_ror) begin
            state_d = S_ROR_SETUP;
            cnt_d   = ld(T_ASR);
          end else begin
            state_d = S_CBR_SETUP;
            cnt_d   = ld(T_CSR);
          end
        end else if (host_req_i) begin
          state_d = S_ACC_SETUP;
          cnt_d   = ld(T_ASR);
        end
      end
      S_ACC_SETUP: if (last) begin
        state_d = S_ACC_RAS;
        cnt_d   = ld(T_RAS);
      end
      S_ACC_RAS: if (last) begin
        cnt_d = ld(T_RP);
        if (is_hid && owed_any_i) begin
          take_o  = 1'b1;
          state_d = S_HID_PRE;
        end else begin
          state_d = S_PRE;
        end
      end
      S_ROR_SETUP, S_CBR_SETUP, S_HID_PRE: if (last) begin
        state_d = S_REF_RAS;
        cnt_d   = ld(T_RAS);
      end
      S_REF_RAS: if (last) begin
        state_d   = S_PRE;
        cnt_d     = ld(T_RP);
        row_adv_o = is_ror;
      end
      S_PRE: if (last) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_PWRUP;
      cnt_q   <= ld(PWRUP_CYC);
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_comb begin
    cas_low = 1'b0;
    unique case (state_q)
      S_ACC_RAS:              cas_low = (cnt_q < CNT_W'(T_RAS - T_RAH));
      S_CBR_SETUP, S_HID_PRE: cas_low = 1'b1;
      S_REF_RAS:              cas_low = !is_ror && (cnt_q >= CNT_W'(T_RAS - T_CHR));
      default:                cas_low = 1'b0;
    endcase
  end

  assign ras_n_o      = !(state_q == S_ACC_RAS || state_q == S_REF_RAS);
  assign cas_n_o      = !cas_low;
  assign host_grant_o = (state_q == S_ACC_SETUP || state_q == S_ACC_RAS);

  always_comb begin
    addr_o = '0;
    if (host_grant_o) addr_o = host_row_i;
    else if (state_q == S_ROR_SETUP || (state_q == S_REF_RAS && is_ror)) addr_o = row_i;
  end

  // Strobe run counters used only by the checks below.
  logic [15:0] ras_lo_cnt, ras_hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_lo_cnt <= '0;
      ras_hi_cnt <= '0;
    end else begin
      ras_lo_cnt <= ras_n_o ? '0 : ras_lo_cnt + 1'b1;
      ras_hi_cnt <= !ras_n_o ? '0 : ((ras_hi_cnt == '1) ? ras_hi_cnt : ras_hi_cnt + 1'b1);
    end
  end

  AST_RAS_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n_o) |-> ras_lo_cnt == 16'(T_RAS)); // R2

  AST_RAS_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n_o) |-> ras_hi_cnt >= 16'(T_RP)); // R3

  AST_FORCED_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && owed_full_i) |=> !host_grant_o); // R10

  AST_CAS_FIRST_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n_o) && !host_grant_o && !is_ror) |-> !cas_n_o); // R7

  AST_ROW_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n_o && !host_grant_o && is_ror) |-> $stable(addr_o)); // R5

endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl #(
  parameter int ROWS       = 256,
  parameter int PERIOD_CYC = 1560,
  parameter int MAX_OWED   = 4,
  parameter int PWRUP_CYC  = 20,
  parameter int T_RAS      = 8,
  parameter int T_RP       = 6,
  parameter int T_ASR      = 1,
  parameter int T_RAH      = 2,
  parameter int T_CSR      = 1,
  parameter int T_CHR      = 2,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic             host_req_i,
  input  logic [ROW_W-1:0] host_row_i,
  output logic             host_grant_o,
  output logic             ras_n_o,
  output logic             cas_n_o,
  output logic [ROW_W-1:0] addr_o
);

  logic             take;
  logic             row_adv;
  logic             owed_any;
  logic             owed_full;
  logic [ROW_W-1:0] row;

  refresh_interval #(
    .PERIOD_CYC(PERIOD_CYC),
    .MAX_OWED  (MAX_OWED)
  ) u_interval (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_i     (take),
    .owed_any_o (owed_any),
    .owed_full_o(owed_full)
  );

  refresh_row_counter #(
    .ROWS(ROWS)
  ) u_rows (
    .clk  (clk),
    .rst_n(rst_n),
    .adv_i(row_adv),
    .row_o(row)
  );

  refresh_sequencer #(
    .ROW_W    (ROW_W),
    .PWRUP_CYC(PWRUP_CYC),
    .T_RAS    (T_RAS),
    .T_RP     (T_RP),
    .T_ASR    (T_ASR),
    .T_RAH    (T_RAH),
    .T_CSR    (T_CSR),
    .T_CHR    (T_CHR)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .host_req_i  (host_req_i),
    .host_row_i  (host_row_i),
    .row_i       (row),
    .owed_any_i  (owed_any),
    .owed_full_i (owed_full),
    .take_o      (take),
    .row_adv_o   (row_adv),
    .host_grant_o(host_grant_o),
    .ras_n_o     (ras_n_o),
    .cas_n_o     (cas_n_o),
    .addr_o      (addr_o)
  );

endmodule

// File: tb/tb_dram_refresh_ctrl.sv
module tb_dram_refresh_ctrl;

  localparam int P_ROWS   = 4;
  localparam int P_PERIOD = 40;
  localparam int P_MAX    = 2;
  localparam int P_PWR    = 5;
  localparam int P_RAS    = 4;
  localparam int P_RP     = 3;
  localparam int P_ASR    = 2;
  localparam int P_RAH    = 1;
  localparam int P_CSR    = 2;
  localparam int P_CHR    = 2;
  localparam int W        = 2;

  localparam int K_NONE = 0, K_ACC = 1, K_ROR = 2, K_CBR = 3, K_HID = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [1:0]   mode;
  logic         req;
  logic [W-1:0] hrow;
  logic         grant, ras_n, cas_n;
  logic [W-1:0] addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dram_refresh_ctrl #(
    .ROWS(P_ROWS), .PERIOD_CYC(P_PERIOD), .MAX_OWED(P_MAX), .PWRUP_CYC(P_PWR),
    .T_RAS(P_RAS), .T_RP(P_RP), .T_ASR(P_ASR), .T_RAH(P_RAH), .T_CSR(P_CSR), .T_CHR(P_CHR)
  ) dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .host_req_i(req), .host_row_i(hrow),
    .host_grant_o(grant), .ras_n_o(ras_n), .cas_n_o(cas_n), .addr_o(addr)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", rq, act, exp);
    end
  endtask

  // Pin-level monitor: state of the current cycle as seen at the strobes.
  int cyc, hi_run, lo_run, cas_lo_run, addr_run, kind, pk, exp_row, n_ref, n_ror, ticks;
  bit prev_r, prev_c;
  logic [W-1:0] prev_a;

  always @(negedge clk) begin
    if (!rst_n) begin
      cyc = 0; hi_run = 0; lo_run = 0; cas_lo_run = 0; addr_run = 0;
      kind = K_NONE; exp_row = 0; n_ref = 0; n_ror = 0;
      prev_r = 1'b1; prev_c = 1'b1; prev_a = '0;
    end else begin
      ticks = (cyc + 1) / P_PERIOD;
      if (cyc < P_PWR)
        chk(ras_n && cas_n && !grant, "R1 power-up idle", {ras_n, cas_n, grant}, 3'b110);

      if (!ras_n && prev_r) begin
        chk(hi_run >= P_RP, "R3 precharge gap", hi_run, P_RP);
        pk = kind;
        if (grant) begin
          kind = K_ACC;
          chk(addr == hrow && addr == prev_a && addr_run >= P_ASR, "R4 access row setup",
              addr_run, P_ASR);
          chk(cas_n, "R4 cas high at ras fall", cas_n, 1);
        end else if (cas_n) begin
          kind = K_ROR;
          chk(mode == 2'd0, "R5 row-only refresh in mode", mode, 0);
          chk(addr == prev_a && addr_run >= P_ASR, "R5 row setup", addr_run, P_ASR);
          chk(int'(addr) == exp_row, "R6 row number", addr, exp_row);
          exp_row = (exp_row + 1) % P_ROWS;
          n_ror++;
        end else if (pk == K_ACC && cas_lo_run > hi_run) begin
          kind = K_HID;
          chk(mode == 2'd2, "R8 hidden only in mode 2", mode, 2);
          chk(hi_run == P_RP, "R8 hidden precharge", hi_run, P_RP);
        end else begin
          kind = K_CBR;
          chk(mode != 2'd0, "R7 cas-first not in mode 0", mode, 1);
          chk(cas_lo_run == P_CSR, "R7 cas lead", cas_lo_run, P_CSR);
          chk(addr == '0, "R7 no row driven", addr, 0);
        end
        if (kind != K_ACC) begin
          n_ref++;
          chk(n_ref <= ticks, "R9 no early refresh", n_ref, ticks);
        end
        chk(ticks - n_ref <= P_MAX + 1, "R10 owed bound", ticks - n_ref, P_MAX + 1);
      end

      if (ras_n && !prev_r) begin
        chk(lo_run == P_RAS, "R2 ras low width", lo_run, P_RAS);
        if (kind == K_ACC)
          chk(cas_lo_run == P_RAS - P_RAH, "R4 cas after row hold", cas_lo_run, P_RAS - P_RAH);
        if (kind == K_ACC || kind == K_ROR)
          chk(addr_run >= P_ASR + P_RAS, "R5 address held through ras", addr_run, P_ASR + P_RAS);
      end

      if (cas_n && !prev_c && !ras_n && (kind == K_CBR || kind == K_HID))
        chk(lo_run == P_CHR, "R7 R8 cas hold", lo_run, P_CHR);

      if (!ras_n && kind != K_ACC && kind != K_NONE)
        chk(!grant, "R11 grant during refresh", grant, 0);

      hi_run     = ras_n ? hi_run + 1 : 0;
      lo_run     = ras_n ? 0 : lo_run + 1;
      cas_lo_run = cas_n ? 0 : cas_lo_run + 1;
      addr_run   = (addr == prev_a) ? addr_run + 1 : 1;
      prev_r = ras_n; prev_c = cas_n; prev_a = addr;
      cyc++;
    end
  end

  logic [15:0] lfsr = 16'hACE1;

  task automatic drive_host(input int n, input bit sporadic);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      req = sporadic ? (lfsr[0] | lfsr[5]) : 1'b1;
      if (!grant) hrow = lfsr[W+2:3];
    end
    req = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; req = 1'b0; hrow = '0; mode = 2'd0;
    for (int m = 0; m < 3; m++) begin
      @(negedge clk); #1;
      rst_n = 1'b0; mode = 2'(m);
      repeat (3) @(negedge clk);
      #2;
      chk(ras_n && cas_n && !grant && addr == '0, "R1 reset state", {ras_n, cas_n, grant}, 3'b110);
      @(negedge clk); #1;
      rst_n = 1'b1;
      repeat (200) @(negedge clk);
      #2;
      chk((cyc / P_PERIOD) - n_ref <= 1, "R9 idle refresh prompt", (cyc / P_PERIOD) - n_ref, 1);
      drive_host(300, 1'b0);
      drive_host(300, 1'b1);
      repeat (120) @(negedge clk);
      #2;
      chk((cyc / P_PERIOD) - n_ref <= 1, "R9 catch-up after traffic", (cyc / P_PERIOD) - n_ref, 1);
      if (m == 0) chk(n_ror > P_ROWS, "R6 row wrap exercised", n_ror, P_ROWS + 1);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule